// File: doc/BRIEF.md
# Sliding-Window Integer Register File

This block is an integer register file whose 32 architectural register numbers are translated onto a larger physical array through a movable window. Eight global rows are seen from every window. The other 24 architectural numbers come from a circular stack of windows. Each window owns eight private locals. It also shares one group of eight with the window on each side of it, so the registers a caller writes as arguments appear to the callee as its incoming registers.

A window pointer selects the current window. A save command moves the pointer down by one and a restore command moves it up by one, and both wrap around the window count. A per-window invalid mask lets the surrounding logic fence off windows whose contents have not been spilled or filled. A move into a fenced window is refused and reported on a trap output, and the spill and fill themselves are left to other logic. There are two combinational read ports and one write port. A read of the register being written in the same cycle returns the new data.

Top module: `wrf_top`

## Requirements
- R1: After reset the window pointer is 0 and every architectural register reads 0 in every window.
- R2: Architectural register 0 reads 0 on both ports at all times, including in a cycle that writes to it. A write to it changes nothing.
- R3: Architectural registers 1 to 7 are globals: one copy is seen from every window.
- R4: Architectural registers 16 to 23 are locals, private to each window. A write to them in one window is not visible from any other window.
- R5: Architectural registers 8 to 15 of window w (outgoing group) are the same storage as architectural registers 24 to 31 (incoming group) of window (w-1) mod NWIN. Incoming register 24+k of window w is outgoing register 8+k of window (w+1) mod NWIN.
- R6: A lone save sets the pointer to (cwp-1) mod NWIN and a lone restore sets it to (cwp+1) mod NWIN at the next clock edge. So a save from window 0 lands in window NWIN-1, and a restore from window NWIN-1 lands in window 0.
- R7: If bit t of winInvalid is 1, where t is the window a lone save or restore would enter, then the move is refused and the pointer holds. In the same cycle, overflowTrap is 1 for a refused save and underflowTrap is 1 for a refused restore. Both are 0 in every other case.
- R8: Asserting saveReq and restoreReq together leaves the pointer unchanged and raises neither trap.
- R9: In a cycle with wrEn=1 and wrAddr equal to a read address other than 0, that read port returns wrData in the same cycle.
- R10: The two read ports are independent: each returns the register named by its own address in the same cycle.
- R11: A write in the same cycle as a save or restore goes to the window that was current before the move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| saveReq | input | 1 | Move to the previous window |
| restoreReq | input | 1 | Move to the next window |
| winInvalid | input | NWIN | Bit t set: window t may not be entered |
| wrEn | input | 1 | Write enable |
| wrAddr | input | 5 | Architectural write register |
| wrData | input | DATA_W | Write data |
| rdAddrA | input | 5 | Architectural read register, port A |
| rdDataA | output | DATA_W | Read data, port A |
| rdAddrB | input | 5 | Architectural read register, port B |
| rdDataB | output | DATA_W | Read data, port B |
| cwp | output | 5 | Current window pointer |
| overflowTrap | output | 1 | Save refused by the invalid mask |
| underflowTrap | output | 1 | Restore refused by the invalid mask |

## Verification
The hardest case to reach is the shared group that spans the wrap point. There, the incoming registers of window NWIN-1 must land on the outgoing registers of window 0, and only a pointer walk across the boundary exposes this. The stimulus therefore walks the pointer with restores through every window, writes all 31 writable registers in each window, and then walks the full circle again reading both ports. A write issued in the same cycle as a save, and moves blocked by the mask at both ends of the circle, are set up separately from a known pointer value.

// File: rtl/wrf_pkg.sv
package wrf_pkg;
  localparam int ARCH_W = 5;
  localparam int PTR_W = 5;

  // Register group decoded from the two top bits of an architectural number
  typedef enum logic [1:0] {
    GRP_GLOBAL = 2'b00,
    GRP_OUT    = 2'b01,
    GRP_LOCAL  = 2'b10,
    GRP_IN     = 2'b11
  } regGroup_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic [PTR_W-1:0] cwp;
    logic             wrStrobe;
  } dpStrobe_t;
endpackage

// File: rtl/wrf_ctrl.sv
module wrf_ctrl
  import wrf_pkg::*;
#(
  parameter int NWIN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             saveReq,
  input  logic             restoreReq,
  input  logic [NWIN-1:0]  winInvalid,
  input  logic             wrEn,
  input  logic [ARCH_W-1:0] wrAddr,
  output dpStrobe_t        strobes,
  output logic [PTR_W-1:0] cwp,
  output logic             overflowTrap,
  output logic             underflowTrap
);
  localparam logic [PTR_W-1:0] LAST_WIN = PTR_W'(NWIN - 1);

  logic [PTR_W-1:0] cwpReg;
  logic [PTR_W-1:0] decCwp;
  logic [PTR_W-1:0] incCwp;
  logic [31:0]      maskWide;
  logic             saveOnly;
  logic             restoreOnly;
  logic             saveOk;
  logic             restoreOk;

  assign maskWide    = 32'(winInvalid);
  assign decCwp      = (cwpReg == '0) ? LAST_WIN : cwpReg - PTR_W'(1);
  assign incCwp      = (cwpReg == LAST_WIN) ? '0 : cwpReg + PTR_W'(1);
  assign saveOnly    = saveReq && !restoreReq;
  assign restoreOnly = restoreReq && !saveReq;

  always_comb begin
    overflowTrap  = saveOnly && maskWide[decCwp];
    underflowTrap = restoreOnly && maskWide[incCwp];
    saveOk        = saveOnly && !maskWide[decCwp];
    restoreOk     = restoreOnly && !maskWide[incCwp];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cwpReg <= '0;
    end else if (saveOk) begin
      cwpReg <= decCwp;
    end else if (restoreOk) begin
      cwpReg <= incCwp;
    end
  end

  always_comb begin
    strobes.cwp      = cwpReg;
    strobes.wrStrobe = wrEn && (wrAddr != '0);
  end

  assign cwp = cwpReg;

  // R6
  save_moves_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (saveOnly && !overflowTrap) |=> (cwpReg == (($past(cwpReg) == '0) ? LAST_WIN : $past(cwpReg) - PTR_W'(1))));

  // R6
  restore_moves_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (restoreOnly && !underflowTrap) |=> (cwpReg == (($past(cwpReg) == LAST_WIN) ? '0 : $past(cwpReg) + PTR_W'(1))));

  // R7
  trap_holds_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overflowTrap || underflowTrap) |=> $stable(cwpReg));

  // R7
  trap_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({overflowTrap, underflowTrap}));

  // R8
  both_cmds_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (saveReq && restoreReq) |=> $stable(cwpReg));

  // R6
  ptr_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cwpReg <= LAST_WIN);
endmodule

// File: rtl/wrf_datapath.sv
module wrf_datapath
  import wrf_pkg::*;
#(
  parameter int NWIN   = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dpStrobe_t         strobes,
  input  logic [ARCH_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ARCH_W-1:0] rdAddr [2],
  output logic [DATA_W-1:0] rdData [2]
);
  localparam int ROWS      = 8 + 16 * NWIN;
  localparam int ROW_W     = $clog2(ROWS);
  localparam int WIN_ROWS  = 16;
  localparam logic [PTR_W-1:0] LAST_WIN = PTR_W'(NWIN - 1);

  logic [DATA_W-1:0] rowMem [ROWS];
  logic [ROW_W-1:0]  wrRow;

  function automatic logic [ROW_W-1:0] rowOf(input logic [ARCH_W-1:0] arch,
                                             input logic [PTR_W-1:0] ptr);
    regGroup_e grp;
    int unsigned win;
    int unsigned slot;
    int unsigned row;
    grp  = regGroup_e'(arch[4:3]);
    slot = 32'(arch[2:0]);
    if (grp == GRP_IN) begin
      win = (ptr == LAST_WIN) ? 0 : 32'(ptr) + 1;
    end else begin
      win = 32'(ptr);
    end
    case (grp)
      GRP_GLOBAL: row = slot;
      GRP_OUT:    row = 8 + WIN_ROWS * win + slot;
      GRP_LOCAL:  row = 8 + WIN_ROWS * win + 8 + slot;
      default:    row = 8 + WIN_ROWS * win + slot;
    endcase
    return ROW_W'(row);
  endfunction

  assign wrRow = rowOf(wrAddr, strobes.cwp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ROWS; i++) begin
        rowMem[i] <= '0;
      end
    end else if (strobes.wrStrobe) begin
      rowMem[wrRow] <= wrData;
    end
  end

  for (genvar p = 0; p < 2; p++) begin : g_rdPort
    logic [ROW_W-1:0] rdRow;
    assign rdRow = rowOf(rdAddr[p], strobes.cwp);
    always_comb begin
      if (rdAddr[p] == '0) begin
        rdData[p] = '0;
      end else if (strobes.wrStrobe && (wrRow == rdRow)) begin
        rdData[p] = wrData;
      end else begin
        rdData[p] = rowMem[rdRow];
      end
    end
  end

  if (NWIN < 3 || NWIN > 32) begin : g_badCfg
    $error("window count out of range");
  end

  // R2
  zero_row_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rowMem[0] == '0);

  // R9
  write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.wrStrobe |=> (rowMem[$past(wrRow)] == $past(wrData)));
endmodule

// File: rtl/wrf_top.sv
module wrf_top
  import wrf_pkg::*;
#(
  parameter int NWIN   = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              saveReq,
  input  logic              restoreReq,
  input  logic [NWIN-1:0]   winInvalid,
  input  logic              wrEn,
  input  logic [4:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [4:0]        rdAddrA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [4:0]        rdAddrB,
  output logic [DATA_W-1:0] rdDataB,
  output logic [4:0]        cwp,
  output logic              overflowTrap,
  output logic              underflowTrap
);
  dpStrobe_t         strobes;
  logic [ARCH_W-1:0] rdAddr [2];
  logic [DATA_W-1:0] rdData [2];

  assign rdAddr[0] = rdAddrA;
  assign rdAddr[1] = rdAddrB;
  assign rdDataA   = rdData[0];
  assign rdDataB   = rdData[1];

  wrf_ctrl #(.NWIN(NWIN)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .saveReq(saveReq), .restoreReq(restoreReq),
    .winInvalid(winInvalid), .wrEn(wrEn), .wrAddr(wrAddr), .strobes(strobes),
    .cwp(cwp), .overflowTrap(overflowTrap), .underflowTrap(underflowTrap)
  );

  wrf_datapath #(.NWIN(NWIN), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData)
  );
endmodule

// File: tb/wrf_top_bench.sv
`timescale 1ns/1ps
module wrf_top_bench;
  localparam int NW = 4;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          saveReq = 1'b0;
  logic          restoreReq = 1'b0;
  logic [NW-1:0] winInvalid = '0;
  logic          wrEn = 1'b0;
  logic [4:0]    wrAddr = '0;
  logic [DW-1:0] wrData = '0;
  logic [4:0]    rdAddrA = '0;
  logic [4:0]    rdAddrB = '0;
  logic [DW-1:0] rdDataA;
  logic [DW-1:0] rdDataB;
  logic [4:0]    cwp;
  logic          overflowTrap;
  logic          underflowTrap;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // Bench model built from R3, R4, R5
  logic [DW-1:0] gModel [8];
  logic [DW-1:0] oModel [NW][8];
  logic [DW-1:0] lModel [NW][8];
  int mCwp = 0;

  always #2 clk = ~clk;

  wrf_top #(.NWIN(NW), .DATA_W(DW)) u_wrf_top (
    .clk(clk), .rst_n(rst_n), .saveReq(saveReq), .restoreReq(restoreReq),
    .winInvalid(winInvalid), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddrA(rdAddrA), .rdDataA(rdDataA), .rdAddrB(rdAddrB), .rdDataB(rdDataB),
    .cwp(cwp), .overflowTrap(overflowTrap), .underflowTrap(underflowTrap)
  );

  function automatic logic [DW-1:0] expVal(input int a);
    if (a == 0) return '0;
    if (a < 8) return gModel[a];
    if (a < 16) return oModel[mCwp][a-8];
    if (a < 24) return lModel[mCwp][a-16];
    return oModel[(mCwp+1) % NW][a-24];
  endfunction

  task automatic modelWrite(input int a, input logic [DW-1:0] v);
    if (a == 0) return;
    if (a < 8) gModel[a] = v;
    else if (a < 16) oModel[mCwp][a-8] = v;
    else if (a < 24) lModel[mCwp][a-16] = v;
    else oModel[(mCwp+1) % NW][a-24] = v;
  endtask

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic readBoth(input int a, input int b, input string tag);
    @(negedge clk);
    rdAddrA = 5'(a);
    rdAddrB = 5'(b);
    #1;
    check(tag, rdDataA, expVal(a));
    check(tag, rdDataB, expVal(b));
  endtask

  task automatic writeReg(input int a, input logic [DW-1:0] v);
    @(negedge clk);
    wrEn = 1'b1;
    wrAddr = 5'(a);
    wrData = v;
    @(posedge clk);
    #1;
    wrEn = 1'b0;
    modelWrite(a, v);
  endtask

  task automatic ctlStep(input bit s, input bit r, input logic [NW-1:0] mask,
                         input bit eOvf, input bit eUnf, input int eCwp, input string tag);
    @(negedge clk);
    saveReq = s;
    restoreReq = r;
    winInvalid = mask;
    #1;
    check({tag, " ovf"}, 32'(overflowTrap), 32'(eOvf));
    check({tag, " unf"}, 32'(underflowTrap), 32'(eUnf));
    @(posedge clk);
    #1;
    saveReq = 1'b0;
    restoreReq = 1'b0;
    winInvalid = '0;
    mCwp = eCwp;
    check({tag, " cwp"}, 32'(cwp), 32'(eCwp));
  endtask

  initial begin
    int cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) gModel[i] = '0;
    for (int w = 0; w < NW; w++)
      for (int i = 0; i < 8; i++) begin
        oModel[w][i] = '0;
        lModel[w][i] = '0;
      end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state across every window
    check("R1 cwp", 32'(cwp), 32'd0);
    for (int w = 0; w < NW; w++) begin
      for (int a = 0; a < 32; a++) readBoth(a, 31 - a, "R1 reset read");
      ctlStep(0, 1, '0, 0, 0, (w + 1) % NW, "R6 restore walk");
    end

    // Fill all windows; R3 R4 R5 R6 sweep
    for (int w = 0; w < NW; w++) begin
      for (int a = 1; a < 32; a++)
        writeReg(a, {8'(w), 8'(a), 16'hC0DE ^ 16'(w * 37 + a)});
      ctlStep(0, 1, '0, 0, 0, (w + 1) % NW, "R6 restore wrap");
    end
    for (int w = 0; w < NW; w++) begin
      for (int a = 0; a < 32; a++) readBoth(a, (a + 13) % 32, "R3 R4 R5 R10 sweep");
      ctlStep(0, 1, '0, 0, 0, (w + 1) % NW, "R6 restore");
    end

    // R5: outs of current window appear as ins after save (crosses 0 -> NW-1)
    for (int k = 0; k < 8; k++) begin
      logic [DW-1:0] outVal;
      @(negedge clk);
      rdAddrA = 5'(8 + k);
      #1;
      outVal = rdDataA;
      ctlStep(1, 0, '0, 0, 0, (mCwp + NW - 1) % NW, "R6 save");
      @(negedge clk);
      rdAddrB = 5'(24 + k);
      #1;
      check("R5 out->in", rdDataB, outVal);
      ctlStep(0, 1, '0, 0, 0, (mCwp + 1) % NW, "R6 restore back");
    end

    // R6 wrap of save from 0
    check("R6 at 0", 32'(cwp), 32'd0);
    ctlStep(1, 0, '0, 0, 0, NW - 1, "R6 save wrap");
    ctlStep(0, 1, '0, 0, 0, 0, "R6 restore wrap");

    // R7: blocked save into window NW-1 and blocked restore into window 1
    ctlStep(1, 0, NW'(1) << (NW - 1), 1, 0, 0, "R7 save blocked");
    ctlStep(0, 1, NW'(2), 0, 1, 0, "R7 restore blocked");
    ctlStep(1, 0, NW'(2), 0, 0, NW - 1, "R7 save allowed");
    ctlStep(0, 1, NW'(1), 0, 1, NW - 1, "R7 restore blocked wrap");
    ctlStep(0, 1, NW'(2), 0, 0, 0, "R7 restore allowed");

    // R8: both commands together
    ctlStep(1, 1, '0, 0, 0, 0, "R8 both");
    ctlStep(1, 1, '1, 0, 0, 0, "R8 both masked");

    // R9 / R2: bypass
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 5'd5; wrData = 32'h1234_5678;
    rdAddrA = 5'd5; rdAddrB = 5'd0;
    #1;
    check("R9 bypass A", rdDataA, 32'h1234_5678);
    check("R2 g0 B", rdDataB, 32'h0);
    @(posedge clk); #1; wrEn = 1'b0; modelWrite(5, 32'h1234_5678);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 5'd27; wrData = 32'hBEEF_0001;
    rdAddrA = 5'd3; rdAddrB = 5'd27;
    #1;
    check("R9 bypass B", rdDataB, 32'hBEEF_0001);
    check("R10 A other", rdDataA, expVal(3));
    @(posedge clk); #1; wrEn = 1'b0; modelWrite(27, 32'hBEEF_0001);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 5'd0; wrData = 32'hFFFF_FFFF;
    rdAddrA = 5'd0; rdAddrB = 5'd0;
    #1;
    check("R2 g0 bypass", rdDataA, 32'h0);
    @(posedge clk); #1; wrEn = 1'b0;
    readBoth(0, 24, "R2 g0 after write");

    // R11: write with save goes to the old window
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 5'd17; wrData = 32'hA5A5_0011; saveReq = 1'b1;
    @(posedge clk); #1;
    wrEn = 1'b0; saveReq = 1'b0;
    modelWrite(17, 32'hA5A5_0011);
    mCwp = (mCwp + NW - 1) % NW;
    check("R11 cwp", 32'(cwp), 32'(mCwp));
    readBoth(17, 24, "R11 new window local");
    ctlStep(0, 1, '0, 0, 0, (mCwp + 1) % NW, "R11 restore");
    readBoth(17, 16, "R11 old window local");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule